// File: doc/BRIEF.md
# Data Memory Access Router

This block sits between a CPU core's external-data-move port and two memory targets: a 1 KB on-chip SRAM and an external memory bus. For each access it checks the address against the on-chip window and looks at a two-bit enable field. It then sends the access to the SRAM port or to the external request/acknowledge port, and returns completion and read data to the core.

The core's configuration register supplies the enable field. That register resets to 00, so after reset every access goes to the external port. Software enables the window by writing a nonzero value to the field. After that, any address inside the window is served by the SRAM in one cycle. Any address above the window still goes to the external port, with no action needed from software.

Top module: `xdata_router`

## Requirements
- R1: With reset asserted and no request pending, `ext_req_o`, `sram_en_o` and `req_ready_o` are all low.
- R2: When `mem_en_i` is 2'b00, no access asserts `sram_en_o`, and every access is sent to the external port, whatever its address.
- R3: When `mem_en_i` is 2'b01, 2'b10 or 2'b11, an access with an address from 16'h0000 to 16'h03FF asserts `sram_en_o`. It drives `sram_addr_o` with address bits [9:0], and `sram_we_o` with the access direction (1 means write).
- R4: When `mem_en_i` is nonzero, an access with an address of 16'h0400 or above does not assert `sram_en_o` and is sent to the external port.
- R5: An internal access completes in the same cycle it is presented: `req_ready_o` is high in that cycle. For a read, `req_rdata_o` equals `sram_rdata_i` in that cycle. For a write, `req_wdata_i` appears on `sram_wdata_o`.
- R6: An external access raises `ext_req_o` in the cycle after `req_valid_i` is first seen. Until `ext_ack_i` arrives, `ext_req_o` stays high and `ext_addr_o`, `ext_we_o` and `ext_wdata_o` hold the captured values, and `req_ready_o` stays low.
- R7: `req_ready_o` goes high in the cycle where `ext_ack_i` is high while `ext_req_o` is high, with `req_rdata_o` equal to `ext_rdata_i`. `ext_req_o` is low in the following cycle.
- R8: `sram_en_o` and `ext_req_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mem_en_i | input | 2 | On-chip window enable field; 00 disables |
| req_valid_i | input | 1 | Core access request, held until ready |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | Access address |
| req_wdata_i | input | 8 | Write data |
| req_ready_o | output | 1 | Access complete |
| req_rdata_o | output | 8 | Read data, valid with ready |
| sram_en_o | output | 1 | SRAM access strobe |
| sram_we_o | output | 1 | SRAM write enable |
| sram_addr_o | output | 10 | SRAM address |
| sram_wdata_o | output | 8 | SRAM write data |
| sram_rdata_i | input | 8 | SRAM read data, same cycle |
| ext_req_o | output | 1 | External bus request |
| ext_we_o | output | 1 | External write flag |
| ext_addr_o | output | 16 | External address |
| ext_wdata_o | output | 8 | External write data |
| ext_ack_i | input | 1 | External acknowledge |
| ext_rdata_i | input | 8 | External read data, valid with ack |

## Verification
The assertions check the following on every cycle: the SRAM strobe and the external request are never high together, nothing reaches the SRAM while the enable field is zero or the address is above the window, an internal access is ready at once, and an external request holds steady with ready low until it is acknowledged. Only the bench scenarios can show that data moves correctly: writes land at the right SRAM locations and read back, external read data returns with the acknowledge, and addresses just either side of the window boundary go to the right target under every enable value and ack latency.

// File: rtl/xdata_pkg.sv
package xdata_pkg;
  typedef enum logic {
    EXT_IDLE = 1'b0,
    EXT_WAIT = 1'b1
  } ext_state_e;
endpackage

// File: rtl/xdata_decode.sv
module xdata_decode #(
  parameter int ADDR_W = 16,
  parameter int WIN_AW = 10,
  parameter int EN_W   = 2
) (
  input  logic [EN_W-1:0]   en_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  logic in_win;

  generate
    if (ADDR_W > WIN_AW) begin : g_upper
      assign in_win = (addr_i[ADDR_W-1:WIN_AW] == '0);
    end else begin : g_full
      assign in_win = 1'b1;
    end
  endgenerate

  // any nonzero enable value maps the window
  assign hit_o = (en_i != '0) && in_win;
endmodule

// File: rtl/xdata_ext_port.sv
module xdata_ext_port
  import xdata_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ack_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              req_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  ext_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      EXT_IDLE: if (start_i) state_d = EXT_WAIT;
      EXT_WAIT: if (ack_i)   state_d = EXT_IDLE;
      default:               state_d = EXT_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= EXT_IDLE;
      we_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == EXT_IDLE && start_i) begin
        we_o    <= we_i;
        addr_o  <= addr_i;
        wdata_o <= wdata_i;
      end
    end
  end

  assign busy_o = (state_q == EXT_WAIT);
  assign req_o  = busy_o;
  assign done_o = busy_o && ack_i;
endmodule

// File: rtl/xdata_resp_mux.sv
module xdata_resp_mux #(
  parameter int DATA_W = 8
) (
  input  logic              int_go_i,
  input  logic              ext_done_i,
  input  logic [DATA_W-1:0] sram_rdata_i,
  input  logic [DATA_W-1:0] ext_rdata_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    ready_o = int_go_i | ext_done_i;
    if (int_go_i)        rdata_o = sram_rdata_i;
    else if (ext_done_i) rdata_o = ext_rdata_i;
    else                 rdata_o = '0;
  end
endmodule

// File: rtl/xdata_router.sv
module xdata_router #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int WIN_AW = 10,
  parameter int EN_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [EN_W-1:0]   mem_en_i,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic [DATA_W-1:0] req_rdata_o,
  output logic              sram_en_o,
  output logic              sram_we_o,
  output logic [WIN_AW-1:0] sram_addr_o,
  output logic [DATA_W-1:0] sram_wdata_o,
  input  logic [DATA_W-1:0] sram_rdata_i,
  output logic              ext_req_o,
  output logic              ext_we_o,
  output logic [ADDR_W-1:0] ext_addr_o,
  output logic [DATA_W-1:0] ext_wdata_o,
  input  logic              ext_ack_i,
  input  logic [DATA_W-1:0] ext_rdata_i
);
  logic win_hit, int_go, ext_start, ext_busy, ext_done;

  xdata_decode #(.ADDR_W(ADDR_W), .WIN_AW(WIN_AW), .EN_W(EN_W)) i_decode (
    .en_i  (mem_en_i),
    .addr_i(req_addr_i),
    .hit_o (win_hit)
  );

  // internal access only while no external transfer is outstanding
  assign int_go    = req_valid_i && win_hit && !ext_busy;
  assign ext_start = req_valid_i && !win_hit && !ext_busy;

  xdata_ext_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ext (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(ext_start),
    .we_i   (req_we_i),
    .addr_i (req_addr_i),
    .wdata_i(req_wdata_i),
    .ack_i  (ext_ack_i),
    .busy_o (ext_busy),
    .done_o (ext_done),
    .req_o  (ext_req_o),
    .we_o   (ext_we_o),
    .addr_o (ext_addr_o),
    .wdata_o(ext_wdata_o)
  );

  xdata_resp_mux #(.DATA_W(DATA_W)) i_resp (
    .int_go_i    (int_go),
    .ext_done_i  (ext_done),
    .sram_rdata_i(sram_rdata_i),
    .ext_rdata_i (ext_rdata_i),
    .ready_o     (req_ready_o),
    .rdata_o     (req_rdata_o)
  );

  assign sram_en_o    = int_go;
  assign sram_we_o    = int_go && req_we_i;
  assign sram_addr_o  = req_addr_i[WIN_AW-1:0];
  assign sram_wdata_o = req_wdata_i;
endmodule

// File: rtl/xdata_router_chk.sv
module xdata_router_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int WIN_AW = 10,
  parameter int EN_W   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [EN_W-1:0]   mem_en_i,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              req_ready_o,
  input logic              sram_en_o,
  input logic              ext_req_o,
  input logic              ext_we_o,
  input logic [ADDR_W-1:0] ext_addr_o,
  input logic [DATA_W-1:0] ext_wdata_o,
  input logic              ext_ack_i
);
  logic addr_high;
  assign addr_high = (req_addr_i >> WIN_AW) != '0;

  AST_NO_DUAL_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sram_en_o && ext_req_o)); // R8
  AST_SRAM_OFF_WHEN_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_en_i == '0) |-> !sram_en_o); // R2
  AST_HIGH_ADDR_EXTERNAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && addr_high) |-> !sram_en_o); // R4
  AST_INT_SAME_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && mem_en_i != '0 && !addr_high && !ext_req_o) |-> (sram_en_o && req_ready_o)); // R5
  AST_EXT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_req_o && !ext_ack_i) |=> (ext_req_o && $stable(ext_addr_o) && $stable(ext_we_o) && $stable(ext_wdata_o))); // R6
  AST_EXT_WAIT_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_req_o && !ext_ack_i) |-> !req_ready_o); // R6
  AST_EXT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_req_o && ext_ack_i) |-> req_ready_o ##1 !ext_req_o); // R7
endmodule

bind xdata_router xdata_router_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_AW(WIN_AW), .EN_W(EN_W)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_en_i   (mem_en_i),
  .req_valid_i(req_valid_i),
  .req_addr_i (req_addr_i),
  .req_ready_o(req_ready_o),
  .sram_en_o  (sram_en_o),
  .ext_req_o  (ext_req_o),
  .ext_we_o   (ext_we_o),
  .ext_addr_o (ext_addr_o),
  .ext_wdata_o(ext_wdata_o),
  .ext_ack_i  (ext_ack_i)
);

// File: tb/test_xdata_router.sv
`timescale 1ns/1ps
module test_xdata_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mem_en = 2'b00;
  logic        valid = 1'b0, we = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        ready;
  logic [7:0]  rdata;
  logic        sram_en, sram_we;
  logic [9:0]  sram_addr;
  logic [7:0]  sram_wdata, sram_rdata;
  logic        ext_req, ext_we;
  logic [15:0] ext_addr;
  logic [7:0]  ext_wdata;
  logic        ext_ack = 1'b0;
  logic [7:0]  ext_rdata = '0;

  int checks = 0, errors = 0;
  logic [7:0] sram_mem [1024];
  logic [7:0] exp_mem  [1024];

  always #10 clk = ~clk; // 50 MHz

  xdata_router i_xdata_router (
    .clk_i(clk), .rst_ni(rst_n), .mem_en_i(mem_en),
    .req_valid_i(valid), .req_we_i(we), .req_addr_i(addr), .req_wdata_i(wdata),
    .req_ready_o(ready), .req_rdata_o(rdata),
    .sram_en_o(sram_en), .sram_we_o(sram_we), .sram_addr_o(sram_addr),
    .sram_wdata_o(sram_wdata), .sram_rdata_i(sram_rdata),
    .ext_req_o(ext_req), .ext_we_o(ext_we), .ext_addr_o(ext_addr),
    .ext_wdata_o(ext_wdata), .ext_ack_i(ext_ack), .ext_rdata_i(ext_rdata)
  );

  // SRAM model: combinational read, write at clock edge
  assign sram_rdata = sram_mem[sram_addr];
  always @(posedge clk) if (sram_en && sram_we) sram_mem[sram_addr] <= sram_wdata;

  function automatic logic [7:0] ext_pattern(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic bit goes_internal(input logic [1:0] en, input logic [15:0] a);
    return (en != 2'b00) && (a < 16'h0400);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] en, input logic w, input logic [15:0] a,
                        input logic [7:0] d, input int lat);
    @(negedge clk);
    mem_en = en; valid = 1'b1; we = w; addr = a; wdata = d;
    #1;
    if (goes_internal(en, a)) begin
      chk("R3 sram_en", sram_en, 1'b1);
      chk("R3 sram_addr", sram_addr, a[9:0]);
      chk("R3 sram_we", sram_we, w);
      chk("R5 ready", ready, 1'b1);
      chk("R8 no ext", ext_req, 1'b0);
      if (w) chk("R5 wdata", sram_wdata, d);
      else   chk("R5 rdata", rdata, exp_mem[a[9:0]]);
      if (w) exp_mem[a[9:0]] = d;
      @(negedge clk);
      valid = 1'b0;
    end else begin
      chk((en == 2'b00) ? "R2 sram_en" : "R4 sram_en", sram_en, 1'b0);
      chk("R6 ready low", ready, 1'b0);
      for (int i = 0; i <= lat; i++) begin
        @(negedge clk);
        if (i == lat) begin ext_ack = 1'b1; ext_rdata = ext_pattern(a); end
        #1;
        chk("R6 ext_req", ext_req, 1'b1);
        chk("R6 ext_addr", ext_addr, a);
        chk("R6 ext_we", ext_we, w);
        if (w) chk("R6 ext_wdata", ext_wdata, d);
        chk("R8 no sram", sram_en, 1'b0);
        if (i < lat) chk("R6 ready wait", ready, 1'b0);
        else begin
          chk("R7 ready", ready, 1'b1);
          if (!w) chk("R7 rdata", rdata, ext_pattern(a));
        end
      end
      @(negedge clk);
      ext_ack = 1'b0; valid = 1'b0;
      #1;
      chk("R7 ext_req drop", ext_req, 1'b0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    for (int i = 0; i < 1024; i++) begin
      sram_mem[i] = 8'h00; exp_mem[i] = 8'h00;
    end
    #5;
    chk("R1 ext_req reset", ext_req, 1'b0);
    chk("R1 sram_en reset", sram_en, 1'b0);
    chk("R1 ready reset", ready, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 ext_req idle", ext_req, 1'b0);

    // directed corners
    access(2'b00, 1'b0, 16'h0000, 8'h00, 0); // R2
    access(2'b00, 1'b1, 16'h03FF, 8'hA5, 2); // R2
    access(2'b01, 1'b1, 16'h03FF, 8'h3C, 0); // R3
    access(2'b01, 1'b0, 16'h03FF, 8'h00, 0); // R5
    access(2'b10, 1'b1, 16'h0000, 8'hC3, 0); // R3
    access(2'b11, 1'b0, 16'h0000, 8'h00, 0); // R5
    access(2'b11, 1'b0, 16'h0400, 8'h00, 0); // R4
    access(2'b01, 1'b1, 16'hFFFF, 8'h77, 5); // R4 R6
    access(2'b10, 1'b0, 16'h8000, 8'h00, 3); // R7

    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [15:0] a;
      logic [1:0]  e;
      e = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 1) == 0) a = 16'($urandom_range(0, 16'h03FF));
      else                           a = 16'($urandom_range(16'h0400, 16'hFFFF));
      access(e, 1'($urandom_range(0, 1)), a, 8'($urandom_range(0, 255)),
             int'($urandom_range(0, 6)));
    end

    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule